// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Access Protection

This block turns 32-bit virtual addresses into 32-bit physical addresses for 4 KB pages. It keeps a small, fully associative table of recent page mappings. A lookup compares the virtual page number with every valid entry in parallel. On a hit, the physical address is the stored physical page number joined to the unchanged 12-bit page offset. The access type is checked against the rights of the matching entry. When the access is allowed, the entry's reference bit is set, and a write also sets its dirty bit. Misses and rights violations are reported; an external handler resolves them.

The handler loads mappings through a fill port. A fill takes the lowest-numbered invalid entry if one exists. Once the table is full, a clock-hand sweep picks the victim. The hand skips entries whose reference bit is set, clears those bits as it passes, and replaces the first entry whose bit is clear. The handler is told the physical page number and dirty state of any valid entry that a fill evicts, so that it can write the page back.

Top module: `tlb_top`

## Requirements
- R1: After synchronous reset every entry is invalid, all result and victim outputs are low, and any lookup reports a miss.
- R2: A lookup request produces its result one clock later. While `rsp_valid` is high exactly one of `rsp_hit`, `rsp_miss`, `rsp_prot` is high, and while it is low all three are low.
- R3: On a hit `rsp_paddr` equals the entry's physical page number in bits 31:12 with `req_vaddr[11:0]` in bits 11:0; on a miss or violation `rsp_paddr` is zero.
- R4: A lookup whose `req_vaddr[31:12]` matches no valid entry reports a miss.
- R5: Rights codes are 2'b00 none, 2'b01 read-only, 2'b10 read/write, 2'b11 execute. Access codes are 2'b00 load, 2'b01 store, 2'b10 fetch, and 2'b11 is reserved. A load is allowed for read-only and read/write, a store only for read/write, and a fetch only for execute; a reserved access is never allowed. A matching entry whose rights forbid the access reports `rsp_prot`.
- R6: A lookup that reports a violation changes neither the reference bit nor the dirty bit of the entry.
- R7: A permitted hit sets the entry's reference bit, and a permitted store hit also sets its dirty bit.
- R8: A fill while any entry is invalid writes the lowest-numbered invalid entry (valid, reference clear, dirty clear) and reports no victim.
- R9: A fill into a full table starts at the hand, clears the reference bit of each entry it passes with the bit set, replaces the first entry with a clear bit, and leaves the hand one past that entry. When every reference bit is set, the entry at the hand is replaced and all reference bits end clear.
- R10: One clock after a fill that evicts a valid entry, `vic_valid` is high for one cycle with that entry's dirty bit on `vic_dirty` and its physical page number on `vic_ppn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type (load, store, fetch) |
| rsp_valid | output | 1 | Lookup result is present |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_prot | output | 1 | Matching entry forbids the access |
| rsp_paddr | output | 32 | Translated physical address |
| fill_valid | input | 1 | Load one mapping |
| fill_vpn | input | 20 | Virtual page number of the new mapping |
| fill_ppn | input | 20 | Physical page number of the new mapping |
| fill_rights | input | 2 | Rights code of the new mapping |
| vic_valid | output | 1 | A valid entry was evicted by the last fill |
| vic_dirty | output | 1 | Evicted entry had been written |
| vic_ppn | output | 20 | Physical page number of the evicted entry |

## Verification
The bench runs all three access types against all four rights codes, plus the reserved access code. A rights check with the encoding or the store/load split reversed turns an expected hit into a violation, or the other way round. A violating store is followed by an eviction of the same entry, and the victim output must show a clear dirty bit. A design that updated the state bits before the rights check would instead protect that entry with its reference bit or report it dirty. The bench sets reference bits on entries ahead of the hand and checks which entry is replaced. It then fills long enough to bring the hand round to an earlier written entry, so a design that forgets to clear passed bits, or never records dirty, evicts the wrong entry or reports a clean page. A final pass with every reference bit set checks that the entry at the hand is taken and that the entry after it falls next.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W  = 32;
    localparam int PA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RD   = 2'b01,
        PERM_RW   = 2'b10,
        PERM_EXEC = 2'b11
    } perm_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_t;

    typedef struct packed {
        logic             valid;
        logic             ref_bit;
        logic             dirty;
        perm_t            perm;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;

    function automatic logic perm_allows(perm_t p, acc_t a);
        case (a)
            ACC_LOAD:  return (p == PERM_RD) || (p == PERM_RW);
            ACC_STORE: return (p == PERM_RW);
            ACC_FETCH: return (p == PERM_EXEC);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N     = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]            valid_vec,
    input  logic [N-1:0][VPN_W-1:0] tag_vec,
    input  logic [VPN_W-1:0]        look_vpn,
    output logic                    any_hit,
    output logic [IDX_W-1:0]        hit_idx
);

    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid_vec[g] && (tag_vec[g] == look_vpn);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end

    assign any_hit = |eq;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     ref_vec,
    input  logic [IDX_W-1:0] hand,
    output logic             use_free,
    output logic [IDX_W-1:0] pick_idx,
    output logic [N-1:0]     clr_mask
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] sweep_idx;
    logic             found;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        found     = 1'b0;
        sweep_idx = hand;
        clr_mask  = '0;
        for (int k = 0; k < N; k++) begin
            if (!found) begin
                if (!ref_vec[hand + IDX_W'(k)]) begin
                    sweep_idx = hand + IDX_W'(k);
                    found     = 1'b1;
                end else begin
                    clr_mask[hand + IDX_W'(k)] = 1'b1;
                end
            end
        end
        if (!(&valid_vec)) clr_mask = '0;
    end

    assign use_free = !(&valid_vec);
    assign pick_idx = use_free ? free_idx : sweep_idx;

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_acc,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_prot,
    output logic [31:0]      rsp_paddr,
    input  logic             fill_valid,
    input  logic [19:0]      fill_vpn,
    input  logic [19:0]      fill_ppn,
    input  logic [1:0]       fill_rights,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [19:0]      vic_ppn
);

    tlb_entry_t              ent [N];
    logic [N-1:0]            valid_vec;
    logic [N-1:0]            ref_vec;
    logic [N-1:0][VPN_W-1:0] tag_vec;
    logic [IDX_W-1:0]        hand;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            valid_vec[i] = ent[i].valid;
            ref_vec[i]   = ent[i].ref_bit;
            tag_vec[i]   = ent[i].vpn;
        end
    end

    logic [VPN_W-1:0] look_vpn;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic             allowed;
    acc_t             acc;

    assign look_vpn = req_vaddr[VA_W-1:OFF_W];
    assign acc      = acc_t'(req_acc);

    tlb_match #(.N(N)) u_match (
        .valid_vec (valid_vec),
        .tag_vec   (tag_vec),
        .look_vpn  (look_vpn),
        .any_hit   (any_hit),
        .hit_idx   (hit_idx)
    );

    assign allowed = perm_allows(ent[hit_idx].perm, acc);

    logic             use_free;
    logic [IDX_W-1:0] pick_idx;
    logic [N-1:0]     clr_mask;

    tlb_victim #(.N(N)) u_victim (
        .valid_vec (valid_vec),
        .ref_vec   (ref_vec),
        .hand      (hand),
        .use_free  (use_free),
        .pick_idx  (pick_idx),
        .clr_mask  (clr_mask)
    );

    logic good_hit;
    assign good_hit = req_valid && any_hit && allowed;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent[i] <= '0;
            hand      <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_paddr <= '0;
            vic_valid <= 1'b0;
            vic_dirty <= 1'b0;
            vic_ppn   <= '0;
        end else begin
            // lookup result stage
            rsp_valid <= req_valid;
            rsp_hit   <= good_hit;
            rsp_miss  <= req_valid && !any_hit;
            rsp_prot  <= req_valid && any_hit && !allowed;
            rsp_paddr <= good_hit ? {ent[hit_idx].ppn, req_vaddr[OFF_W-1:0]} : '0;

            // sweep clears first, so a same-cycle permitted hit keeps its bit
            if (fill_valid) begin
                for (int i = 0; i < N; i++) begin
                    if (clr_mask[i]) ent[i].ref_bit <= 1'b0;
                end
            end

            if (good_hit) begin
                ent[hit_idx].ref_bit <= 1'b1;
                if (acc == ACC_STORE) ent[hit_idx].dirty <= 1'b1;
            end

            if (fill_valid) begin
                ent[pick_idx].valid   <= 1'b1;
                ent[pick_idx].ref_bit <= 1'b0;
                ent[pick_idx].dirty   <= 1'b0;
                ent[pick_idx].perm    <= perm_t'(fill_rights);
                ent[pick_idx].vpn     <= fill_vpn;
                ent[pick_idx].ppn     <= fill_ppn;
                vic_valid             <= !use_free;
                vic_dirty             <= !use_free && ent[pick_idx].dirty;
                vic_ppn               <= use_free ? '0 : ent[pick_idx].ppn;
                if (!use_free) hand   <= pick_idx + 1'b1;
            end else begin
                vic_valid <= 1'b0;
                vic_dirty <= 1'b0;
                vic_ppn   <= '0;
            end
        end
    end

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic        rsp_prot,
    input logic [31:0] rsp_paddr,
    input logic        fill_valid,
    input logic        vic_valid
);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot}) == 1);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rsp_valid == $past(req_valid)));

    // R3
    offset_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && rsp_hit) |-> (rsp_paddr[11:0] == $past(req_vaddr[11:0])));

    // R3
    nohit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_miss || rsp_prot) |-> (rsp_paddr == 32'h0));

    // R10
    victim_follows_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && vic_valid) |-> $past(fill_valid));

endmodule

bind tlb_top tlb_chk u_tlb_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_prot   (rsp_prot),
    .rsp_paddr  (rsp_paddr),
    .fill_valid (fill_valid),
    .vic_valid  (vic_valid)
);

// File: tb/tlb_top_tb_top.sv
module tlb_top_tb_top;

    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_acc;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_prot;
    logic [31:0] rsp_paddr;
    logic        fill_valid;
    logic [19:0] fill_vpn, fill_ppn;
    logic [1:0]  fill_rights;
    logic        vic_valid, vic_dirty;
    logic [19:0] vic_ppn;

    int checks = 0;
    int errors = 0;

    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];
    logic [1:0]  m_perm  [N];
    logic [19:0] next_vpn;
    logic [19:0] next_ppn;

    always #5 clk = ~clk;

    tlb_top #(.N(N)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rights(fill_rights),
        .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_ppn(vic_ppn)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic allowed(logic [1:0] perm, logic [1:0] acc);
        case (acc)
            2'b00: return perm == 2'b01 || perm == 2'b10;
            2'b01: return perm == 2'b10;
            2'b10: return perm == 2'b11;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_reset();
        rst = 1'b1; req_valid = 0; req_vaddr = '0; req_acc = '0;
        fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_rights = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one lookup; outputs sampled at the negedge after the capturing edge
    task automatic lookup(logic [19:0] vpn, logic [11:0] off, logic [1:0] acc);
        req_valid = 1'b1; req_vaddr = {vpn, off}; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] perm);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = perm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic expect_hit(string req, int e, logic [1:0] acc);
        lookup(m_vpn[e], 12'h5A3, acc);
        check(req, {rsp_valid, rsp_hit, rsp_miss, rsp_prot}, 4'b1100);
        check(req, rsp_paddr, {m_ppn[e], 12'h5A3});
    endtask

    task automatic fill_all_initial();
        for (int k = 0; k < N; k++) begin
            m_vpn[k]  = 20'h10000 + 20'(k);
            m_ppn[k]  = 20'h00200 + 20'(3 * k);
            m_perm[k] = 2'((k + 1) % 4);
            fill(m_vpn[k], m_ppn[k], m_perm[k]);
            check("R8 no victim while free entries remain", {31'h0, vic_valid}, 32'h0);
        end
    endtask

    // refill with a fresh read/write mapping and expect entry e evicted
    task automatic refill_expect(string req, int e, logic exp_dirty);
        logic [19:0] old_ppn;
        old_ppn = m_ppn[e];
        fill(next_vpn, next_ppn, 2'b10);
        check(req, {31'h0, vic_valid}, 32'h1);
        check(req, {12'h0, vic_ppn}, {12'h0, old_ppn});
        check(req, {31'h0, vic_dirty}, {31'h0, exp_dirty});
        m_vpn[e] = next_vpn; m_ppn[e] = next_ppn; m_perm[e] = 2'b10;
        next_vpn++; next_ppn++;
    endtask

    task automatic test_reset();
        check("R1 reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_prot, vic_valid}, 5'b0);
        lookup(20'h12345, 12'h678, 2'b00);
        check("R1 R4 empty table misses", {rsp_valid, rsp_hit, rsp_miss, rsp_prot}, 4'b1010);
        check("R3 miss address is zero", rsp_paddr, 32'h0);
        @(negedge clk);
        check("R2 result lasts one cycle", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic test_rights();
        for (int e = 0; e < 4; e++) begin
            for (int a = 0; a < 4; a++) begin
                lookup(m_vpn[e], 12'hABC, 2'(a));
                if (allowed(m_perm[e], 2'(a))) begin
                    check("R5 permitted access hits", {rsp_hit, rsp_prot}, 2'b10);
                    check("R3 hit address", rsp_paddr, {m_ppn[e], 12'hABC});
                end else begin
                    check("R5 forbidden access violates", {rsp_hit, rsp_prot}, 2'b01);
                    check("R3 violation address is zero", rsp_paddr, 32'h0);
                end
            end
        end
        lookup(20'h3FFFF, 12'h001, 2'b00);
        check("R4 unmapped page misses", {rsp_valid, rsp_miss}, 2'b11);
    endtask

    task automatic test_violation_no_update();
        // entry 0 is read-only: a store violates
        lookup(m_vpn[0], 12'h010, 2'b01);
        check("R6 store to read-only violates", {rsp_hit, rsp_prot}, 2'b01);
        refill_expect("R6 violated entry still unreferenced and clean", 0, 1'b0);
    endtask

    task automatic test_hand_skip();
        expect_hit("R7 store to read/write hits", 1, 2'b01);
        expect_hit("R7 fetch from execute hits", 2, 2'b10);
        refill_expect("R9 hand skips referenced entries", 3, 1'b0);
    endtask

    task automatic test_wrap_dirty();
        for (int e = 4; e < N; e++) refill_expect("R9 hand advances in order", e, 1'b0);
        refill_expect("R9 hand wraps to entry 0", 0, 1'b0);
        refill_expect("R7 R10 written entry evicted dirty", 1, 1'b1);
    endtask

    task automatic test_all_referenced();
        for (int e = 0; e < N; e++) begin
            lookup(m_vpn[e], 12'h000, (m_perm[e] == 2'b11) ? 2'b10 : 2'b00);
            check("R7 reference sweep hits", {31'h0, rsp_hit}, 32'h1);
        end
        refill_expect("R9 all referenced takes hand entry", 2, 1'b0);
        refill_expect("R9 passed bits were cleared", 3, 1'b0);
    endtask

    initial begin
        next_vpn = 20'h20000;
        next_ppn = 20'h0F000;
        do_reset();
        test_reset();
        fill_all_initial();
        test_rights();

        do_reset();
        fill_all_initial();
        test_violation_no_update();
        test_hand_skip();
        test_wrap_dirty();
        test_all_referenced();

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule